// File: doc/BRIEF.md
# FR-FCFS DRAM Request Selector

This block holds a small queue of pending DRAM requests, oldest at the head, and picks which one goes out next. Each entry carries a bank index and a row address. Entries are pushed at the tail and popped from the head. On an issue strobe the block chooses one entry and rotates it to the head in the same clock edge. All other entries keep their relative age. The surrounding controller then reads the head and pops it when the command has gone out.

The choice depends on per-bank state that the controller supplies: the row currently open in each bank, the time at which each bank becomes free, and a running time value. A policy input selects between strict arrival order and the row-hit-first scheme. In the row-hit-first scheme, any request that hits its bank's open row wins. When no request hits, the oldest request whose bank is ready, or is among the earliest-free banks, wins. The same instance suits a read queue or a write queue, because the selection does not depend on the request direction.

Top module: `dram_req_picker`

## Requirements
- R1: After reset the queue is empty: `count_o` is 0, `head_valid_o` is 0 and `sel_valid_o` is 0.
- R2: A push appends one entry at the tail unless the queue already holds DEPTH entries, in which case the push is dropped. A pop removes the head. A pop is ignored when the queue is empty or when `issue_i` is high in the same cycle.
- R3: With `policy_i` = 0 (arrival order), an issue on a non-empty queue selects index 0 and leaves the queue order unchanged.
- R4: With `policy_i` = 1 (row-hit-first), an entry is a row hit when its row equals the `open_row_i` slice of its bank (bank b occupies bits [b*ROW_W +: ROW_W]). The oldest row hit is selected and `sel_hit_o` is 1.
- R5: A row hit is selected even when an older entry targets a bank that is ready.
- R6: With `policy_i` = 1 and no row hit, the oldest entry is selected whose bank free time (`free_at_i` bits [b*TIME_W +: TIME_W]) is less than or equal to `now_i`. In this case `sel_hit_o` is 0.
- R7: An entry also qualifies under R6 when its bank is in the earliest set. The earliest set holds every bank referenced by a valid entry whose free time equals the minimum over those referenced banks. Banks that no valid entry references play no part in the minimum.
- R8: After an issue the selected entry sits at the head. Entries older than it move down by one place, entries younger stay where they are, and the count is unchanged.
- R9: An issue on an empty queue leaves `sel_valid_o` at 0 and changes nothing.
- R10: `sel_valid_o` is high for exactly the one cycle after an accepted issue. `sel_idx_o` then gives the position of the winner before the reorder, which is always below the count at issue time.
- R11: A push in the same cycle as an issue is appended at the tail after the reorder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| policy_i | input | 1 | 0 = arrival order, 1 = row-hit-first |
| now_i | input | TIME_W | Current time |
| open_row_i | input | NBANK*ROW_W | Open row per bank, bank b in slice b |
| free_at_i | input | NBANK*TIME_W | Time each bank becomes free, bank b in slice b |
| push_i | input | 1 | Append a request at the tail |
| push_bank_i | input | BANK_W | Bank of the pushed request |
| push_row_i | input | ROW_W | Row of the pushed request |
| pop_i | input | 1 | Remove the head entry |
| issue_i | input | 1 | Choose an entry and move it to the head |
| sel_valid_o | output | 1 | A choice was made on the previous edge |
| sel_idx_o | output | IDX_W | Position of the chosen entry before the reorder |
| sel_hit_o | output | 1 | The choice was a row hit |
| head_valid_o | output | 1 | Queue is not empty |
| head_bank_o | output | BANK_W | Bank of the head entry |
| head_row_o | output | ROW_W | Row of the head entry |
| count_o | output | CNT_W | Number of queued entries |

## Verification
The bench builds the block with DEPTH = 8, NBANK = 4, ROW_W = 8 and TIME_W = 12. A depth of 8 makes it cheap to fill the queue, to try a push on a full queue and to place a row hit in the last slot. With only four banks, several entries share a bank. This lets the bench build ties in the earliest set, row mismatches on a shared bank, and idle banks that must stay out of the minimum free-time calculation.

// File: rtl/drp_pkg.sv
package drp_pkg;

    typedef enum logic {
        POL_FCFS   = 1'b0,
        POL_FRFCFS = 1'b1
    } drp_policy_e;

endpackage

// File: rtl/drp_earliest.sv
// Marks every bank that a valid entry references and whose free time is the
// lowest among the referenced banks.
module drp_earliest #(
    parameter int DEPTH  = 16,
    parameter int NBANK  = 8,
    parameter int TIME_W = 16,
    parameter int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic [DEPTH-1:0]        ent_valid_i,
    input  logic [DEPTH*BANK_W-1:0] ent_bank_i,
    input  logic [NBANK*TIME_W-1:0] free_at_i,
    output logic [NBANK-1:0]        early_o
);

    logic [NBANK-1:0]  used;
    logic [TIME_W-1:0] min_t;

    always_comb begin
        used = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ent_valid_i[i]) begin
                used[ent_bank_i[i*BANK_W +: BANK_W]] = 1'b1;
            end
        end
        min_t = '1;
        for (int b = 0; b < NBANK; b++) begin
            if (used[b] && (free_at_i[b*TIME_W +: TIME_W] <= min_t)) begin
                min_t = free_at_i[b*TIME_W +: TIME_W];
            end
        end
    end

    always_comb begin
        for (int b = 0; b < NBANK; b++) begin
            early_o[b] = used[b] && (free_at_i[b*TIME_W +: TIME_W] == min_t);
        end
    end

endmodule

// File: rtl/drp_first_set.sv
// Lowest-index set bit: the oldest qualifying entry.
module drp_first_set #(
    parameter int N  = 16,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/dram_req_picker.sv
module dram_req_picker
    import drp_pkg::*;
#(
    parameter  int DEPTH  = 16,
    parameter  int NBANK  = 8,
    parameter  int ROW_W  = 14,
    parameter  int TIME_W = 16,
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    policy_i,
    input  logic [TIME_W-1:0]       now_i,
    input  logic [NBANK*ROW_W-1:0]  open_row_i,
    input  logic [NBANK*TIME_W-1:0] free_at_i,
    input  logic                    push_i,
    input  logic [BANK_W-1:0]       push_bank_i,
    input  logic [ROW_W-1:0]        push_row_i,
    input  logic                    pop_i,
    input  logic                    issue_i,
    output logic                    sel_valid_o,
    output logic [IDX_W-1:0]        sel_idx_o,
    output logic                    sel_hit_o,
    output logic                    head_valid_o,
    output logic [BANK_W-1:0]       head_bank_o,
    output logic [ROW_W-1:0]        head_row_o,
    output logic [CNT_W-1:0]        count_o
);

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0]  q;
        logic [CNT_W-1:0]  cnt;
        logic              sel_v;
        logic [IDX_W-1:0]  sel_idx;
        logic              sel_hit;
    } state_t;

    state_t s_d, s_q;

    logic [DEPTH-1:0]        ent_valid;
    logic [DEPTH-1:0]        ent_hit;
    logic [DEPTH-1:0]        ent_rdy;
    logic [DEPTH*BANK_W-1:0] ent_bank_flat;
    logic [NBANK-1:0]        early;
    logic                    hit_found, rdy_found;
    logic [IDX_W-1:0]        hit_idx, rdy_idx;
    logic [IDX_W-1:0]        pick_idx;
    logic                    pick_hit;

    // Per-entry qualification against the bank state.
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        assign ent_valid[g] = (CNT_W'(g) < s_q.cnt);
        assign ent_bank_flat[g*BANK_W +: BANK_W] = s_q.q[g].bank;
        assign ent_hit[g] = ent_valid[g] &&
            (open_row_i[s_q.q[g].bank*ROW_W +: ROW_W] == s_q.q[g].row);
        assign ent_rdy[g] = ent_valid[g] &&
            ((free_at_i[s_q.q[g].bank*TIME_W +: TIME_W] <= now_i) ||
             early[s_q.q[g].bank]);
    end

    drp_earliest #(
        .DEPTH (DEPTH),
        .NBANK (NBANK),
        .TIME_W(TIME_W),
        .BANK_W(BANK_W)
    ) u_early (
        .ent_valid_i(ent_valid),
        .ent_bank_i (ent_bank_flat),
        .free_at_i  (free_at_i),
        .early_o    (early)
    );

    drp_first_set #(.N(DEPTH), .IW(IDX_W)) u_hit_pick (
        .req_i  (ent_hit),
        .found_o(hit_found),
        .idx_o  (hit_idx)
    );

    drp_first_set #(.N(DEPTH), .IW(IDX_W)) u_rdy_pick (
        .req_i  (ent_rdy),
        .found_o(rdy_found),
        .idx_o  (rdy_idx)
    );

    // Winner: row hit first, then ready or earliest bank, else the head.
    always_comb begin
        pick_idx = '0;
        pick_hit = 1'b0;
        if (drp_policy_e'(policy_i) == POL_FRFCFS) begin
            if (hit_found) begin
                pick_idx = hit_idx;
                pick_hit = 1'b1;
            end else if (rdy_found) begin
                pick_idx = rdy_idx;
            end
        end
    end

    always_comb begin
        s_d         = s_q;
        s_d.sel_v   = 1'b0;
        s_d.sel_hit = 1'b0;
        if (issue_i) begin
            if (s_q.cnt != '0) begin
                s_d.sel_v   = 1'b1;
                s_d.sel_idx = pick_idx;
                s_d.sel_hit = pick_hit;
                s_d.q[0]    = s_q.q[pick_idx];
                for (int i = 1; i < DEPTH; i++) begin
                    if (IDX_W'(i) <= pick_idx) begin
                        s_d.q[i] = s_q.q[i-1];
                    end
                end
            end
        end else if (pop_i && (s_q.cnt != '0)) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                s_d.q[i] = s_q.q[i+1];
            end
            s_d.q[DEPTH-1] = '0;
            s_d.cnt        = s_q.cnt - 1'b1;
        end
        if (push_i && (s_d.cnt < CNT_W'(DEPTH))) begin
            s_d.q[s_d.cnt[IDX_W-1:0]] = '{bank: push_bank_i, row: push_row_i};
            s_d.cnt = s_d.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sel_valid_o  = s_q.sel_v;
    assign sel_idx_o    = s_q.sel_idx;
    assign sel_hit_o    = s_q.sel_hit;
    assign head_valid_o = (s_q.cnt != '0);
    assign head_bank_o  = s_q.q[0].bank;
    assign head_row_o   = s_q.q[0].row;
    assign count_o      = s_q.cnt;

endmodule

// File: rtl/drp_checker.sv
module drp_checker #(
    parameter int DEPTH  = 16,
    parameter int NBANK  = 8,
    parameter int ROW_W  = 14,
    parameter int BANK_W = 3,
    parameter int IDX_W  = 4,
    parameter int CNT_W  = 5
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic                   policy_i,
    input logic                   push_i,
    input logic                   issue_i,
    input logic [NBANK*ROW_W-1:0] open_row_i,
    input logic                   sel_valid_o,
    input logic [IDX_W-1:0]       sel_idx_o,
    input logic                   sel_hit_o,
    input logic [BANK_W-1:0]      head_bank_o,
    input logic [ROW_W-1:0]       head_row_o,
    input logic [CNT_W-1:0]       count_o
);

    logic [NBANK*ROW_W-1:0] open_prev;
    logic [ROW_W-1:0]       open_of_head;

    always_ff @(posedge clk_i) begin
        open_prev <= open_row_i;
    end

    assign open_of_head = open_prev[head_bank_o*ROW_W +: ROW_W];

    p_count_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        count_o <= CNT_W'(DEPTH));

    p_fcfs_keeps_head_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_i && !policy_i && (count_o != '0)) |=>
        ((sel_idx_o == '0) && $stable(head_row_o) && $stable(head_bank_o)));

    p_hit_at_head_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_valid_o && sel_hit_o) |-> (head_row_o == open_of_head));

    p_count_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_i && !push_i) |=> (count_o == $past(count_o)));

    p_empty_issue_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_i && (count_o == '0)) |=> !sel_valid_o);

    p_sel_follows_issue_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_valid_o |-> $past(issue_i));

    p_idx_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_valid_o |-> (CNT_W'(sel_idx_o) < $past(count_o)));

endmodule

bind dram_req_picker drp_checker #(
    .DEPTH (DEPTH),
    .NBANK (NBANK),
    .ROW_W (ROW_W),
    .BANK_W(BANK_W),
    .IDX_W (IDX_W),
    .CNT_W (CNT_W)
) u_drp_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .policy_i    (policy_i),
    .push_i      (push_i),
    .issue_i     (issue_i),
    .open_row_i  (open_row_i),
    .sel_valid_o (sel_valid_o),
    .sel_idx_o   (sel_idx_o),
    .sel_hit_o   (sel_hit_o),
    .head_bank_o (head_bank_o),
    .head_row_o  (head_row_o),
    .count_o     (count_o)
);

// File: tb/dram_req_picker_tb.sv
module dram_req_picker_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 8;
    localparam int NBANK  = 4;
    localparam int ROW_W  = 8;
    localparam int TIME_W = 12;
    localparam int BANK_W = 2;
    localparam int IDX_W  = 3;
    localparam int CNT_W  = 4;
    localparam int NOW    = 100;
    localparam int NVEC   = 10;

    // Entry i: bank bk[2i+:2], row rw[8i+:8]; bank b free at NOW + late[4b+:4].
    // Bank b has open row 8'hA0 + b.
    typedef struct packed {
        logic        pol;
        logic [2:0]  n;
        logic [7:0]  bk;
        logic [31:0] rw;
        logic [15:0] late;
        logic [2:0]  xi;
        logic        xh;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 3'd3, {2'd0,2'd2,2'd1,2'd0}, 32'h0000A100, 16'h0055, 3'd0, 1'b0},
        '{1'b1, 3'd3, {2'd0,2'd2,2'd1,2'd0}, 32'h0000A100, 16'h0055, 3'd1, 1'b1},
        '{1'b1, 3'd2, {2'd0,2'd0,2'd3,2'd2}, 32'h0000A300, 16'h9000, 3'd1, 1'b1},
        '{1'b1, 3'd4, {2'd3,2'd2,2'd1,2'd0}, 32'h01010101, 16'h0035, 3'd2, 1'b0},
        '{1'b1, 3'd4, {2'd0,2'd2,2'd1,2'd0}, 32'h03020201, 16'h0447, 3'd1, 1'b0},
        '{1'b1, 3'd3, {2'd0,2'd0,2'd1,2'd0}, 32'h00050101, 16'h1126, 3'd1, 1'b0},
        '{1'b1, 3'd4, {2'd0,2'd1,2'd2,2'd0}, 32'h00A1A200, 16'h0003, 3'd1, 1'b1},
        '{1'b1, 3'd4, {2'd3,2'd2,2'd1,2'd0}, 32'hA3030201, 16'h0000, 3'd3, 1'b1},
        '{1'b1, 3'd1, {2'd0,2'd0,2'd0,2'd1}, 32'h00000007, 16'h0090, 3'd0, 1'b0},
        '{1'b1, 3'd3, {2'd0,2'd2,2'd1,2'd2}, 32'h00A2A2A1, 16'h0200, 3'd2, 1'b1}
    };

    logic                    clk;
    logic                    rst_ni;
    logic                    policy_i;
    logic [TIME_W-1:0]       now_i;
    logic [NBANK*ROW_W-1:0]  open_row_i;
    logic [NBANK*TIME_W-1:0] free_at_i;
    logic                    push_i;
    logic [BANK_W-1:0]       push_bank_i;
    logic [ROW_W-1:0]        push_row_i;
    logic                    pop_i;
    logic                    issue_i;
    logic                    sel_valid_o;
    logic [IDX_W-1:0]        sel_idx_o;
    logic                    sel_hit_o;
    logic                    head_valid_o;
    logic [BANK_W-1:0]       head_bank_o;
    logic [ROW_W-1:0]        head_row_o;
    logic [CNT_W-1:0]        count_o;

    int n_chk = 0;
    int n_err = 0;
    int xb [DEPTH];
    int xr [DEPTH];

    dram_req_picker #(
        .DEPTH (DEPTH),
        .NBANK (NBANK),
        .ROW_W (ROW_W),
        .TIME_W(TIME_W)
    ) u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_ni),
        .policy_i    (policy_i),
        .now_i       (now_i),
        .open_row_i  (open_row_i),
        .free_at_i   (free_at_i),
        .push_i      (push_i),
        .push_bank_i (push_bank_i),
        .push_row_i  (push_row_i),
        .pop_i       (pop_i),
        .issue_i     (issue_i),
        .sel_valid_o (sel_valid_o),
        .sel_idx_o   (sel_idx_o),
        .sel_hit_o   (sel_hit_o),
        .head_valid_o(head_valid_o),
        .head_bank_o (head_bank_o),
        .head_row_o  (head_row_o),
        .count_o     (count_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(input int b, input int r);
        push_i      = 1'b1;
        push_bank_i = BANK_W'(b);
        push_row_i  = ROW_W'(r);
        tick();
        push_i = 1'b0;
    endtask

    task automatic set_late(input logic [15:0] late);
        for (int b = 0; b < NBANK; b++) begin
            free_at_i[b*TIME_W +: TIME_W] = TIME_W'(NOW + int'(late[b*4 +: 4]));
        end
    endtask

    task automatic drain();
        for (int k = 0; k < DEPTH + 1; k++) begin
            if (count_o != '0) begin
                pop_i = 1'b1;
                tick();
                pop_i = 1'b0;
            end
        end
    endtask

    task automatic drain_check(input string req, input int n);
        for (int k = 0; k < n; k++) begin
            chk(req, "head bank", int'(head_bank_o), xb[k]);
            chk(req, "head row", int'(head_row_o), xr[k]);
            pop_i = 1'b1;
            tick();
            pop_i = 1'b0;
        end
        chk(req, "count after drain", int'(count_o), 0);
    endtask

    task automatic issue(input logic pol);
        policy_i = pol;
        issue_i  = 1'b1;
        tick();
        issue_i = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        vec_t  t;
        string tag [NVEC] = '{"R3","R4","R5","R6","R7","R7","R4","R4","R7","R4"};
        int    k;

        rst_ni      = 1'b0;
        policy_i    = 1'b0;
        now_i       = TIME_W'(NOW);
        push_i      = 1'b0;
        push_bank_i = '0;
        push_row_i  = '0;
        pop_i       = 1'b0;
        issue_i     = 1'b0;
        for (int b = 0; b < NBANK; b++) begin
            open_row_i[b*ROW_W +: ROW_W] = ROW_W'(8'hA0 + b);
        end
        set_late(16'h0000);
        repeat (3) tick();

        // R1 reset state
        chk("R1", "count", int'(count_o), 0);
        chk("R1", "head_valid", int'(head_valid_o), 0);
        chk("R1", "sel_valid", int'(sel_valid_o), 0);
        rst_ni = 1'b1;
        tick();

        // R9 issue on empty queue
        issue(1'b1);
        chk("R9", "sel_valid on empty", int'(sel_valid_o), 0);
        chk("R9", "count on empty", int'(count_o), 0);

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            t = VEC[v];
            drain();
            set_late(t.late);
            for (int e = 0; e < int'(t.n); e++) begin
                push(int'(t.bk[e*2 +: 2]), int'(t.rw[e*8 +: 8]));
            end
            chk("R2", "count after load", int'(count_o), int'(t.n));
            issue(t.pol);
            chk("R10", "sel_valid", int'(sel_valid_o), 1);
            chk(tag[v], "sel_idx", int'(sel_idx_o), int'(t.xi));
            chk(tag[v], "sel_hit", int'(sel_hit_o), int'(t.xh));
            tick();
            chk("R10", "sel_valid drop", int'(sel_valid_o), 0);
            xb[0] = int'(t.bk[t.xi*2 +: 2]);
            xr[0] = int'(t.rw[t.xi*8 +: 8]);
            k = 1;
            for (int e = 0; e < int'(t.n); e++) begin
                if (e != int'(t.xi)) begin
                    xb[k] = int'(t.bk[e*2 +: 2]);
                    xr[k] = int'(t.rw[e*8 +: 8]);
                    k++;
                end
            end
            drain_check("R8", int'(t.n));
        end

        // R2 full queue drops the extra push; pop ignored during issue
        set_late(16'h0000);
        for (int i = 0; i < DEPTH + 1; i++) begin
            push(i % NBANK, i + 1);
        end
        chk("R2", "count when full", int'(count_o), DEPTH);
        policy_i = 1'b1;
        issue_i  = 1'b1;
        pop_i    = 1'b1;
        tick();
        issue_i = 1'b0;
        pop_i   = 1'b0;
        chk("R2", "pop with issue ignored", int'(count_o), DEPTH);
        for (int i = 0; i < DEPTH; i++) begin
            xb[i] = i % NBANK;
            xr[i] = i + 1;
        end
        drain_check("R2", DEPTH);

        // R2 pop on empty queue
        pop_i = 1'b1;
        tick();
        pop_i = 1'b0;
        chk("R2", "pop on empty count", int'(count_o), 0);
        chk("R2", "pop on empty head_valid", int'(head_valid_o), 0);

        // R11 push in the same cycle as an issue
        set_late(16'h5555);
        push(0, 8'h01);
        push(1, 8'hA1);
        policy_i    = 1'b1;
        issue_i     = 1'b1;
        push_i      = 1'b1;
        push_bank_i = 2'd2;
        push_row_i  = 8'h55;
        tick();
        issue_i = 1'b0;
        push_i  = 1'b0;
        chk("R4", "sel_idx with push", int'(sel_idx_o), 1);
        chk("R11", "count with push", int'(count_o), 3);
        xb[0] = 1; xr[0] = 8'hA1;
        xb[1] = 0; xr[1] = 8'h01;
        xb[2] = 2; xr[2] = 8'h55;
        drain_check("R11", 3);

        // R8 row hit in the last slot of a full queue
        set_late(16'h5555);
        for (int i = 0; i < DEPTH - 1; i++) begin
            push(i % NBANK, i + 1);
        end
        push(3, 8'hA3);
        issue(1'b1);
        chk("R4", "sel_idx last slot", int'(sel_idx_o), DEPTH - 1);
        chk("R4", "sel_hit last slot", int'(sel_hit_o), 1);
        xb[0] = 3; xr[0] = 8'hA3;
        for (int i = 0; i < DEPTH - 1; i++) begin
            xb[i+1] = i % NBANK;
            xr[i+1] = i + 1;
        end
        drain_check("R8", DEPTH);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule